// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind a two-wire serial bus engine in a small non-volatile storage macro of 128 bytes. The engine passes it a starting word address, one strobe per received data byte, and markers for the start and stop conditions it decodes. The block gathers up to four bytes of one page in a staging buffer. Each slot carries its own valid flag, and the slot index steps through the page with wrap-around.

When the engine reports a stop and at least one byte is staged, the block starts a write cycle of fixed length. During that cycle it holds a busy flag and ignores every strobe from the engine. On the last cycle of the window it copies the flagged bytes into a register-based array and clears the flags. A separate combinational port reads the array at any time. The bus protocol itself is decoded elsewhere.

Top module: `pwb_commit_top`

## Requirements
- R1: After reset `busy` is 0 and every array location reads 0x00.
- R2: The first byte after an address load is stored at the loaded address. Address bits [6:2] are the page and bits [1:0] are the slot within the page.
- R3: Each accepted byte advances only the slot bits [1:0] by one, wrapping from 3 to 0. The page bits [6:2] do not change.
- R4: If more than four bytes arrive before the stop, the later bytes overwrite the earlier bytes in the same slots, and the array receives the last byte written to each slot.
- R5: The array does not change when the stop arrives. The staged bytes appear on the read port in the first cycle after `busy` falls.
- R6: A stop with at least one staged byte raises `busy` in the next cycle. `busy` then stays high for exactly `WR_CYCLES` clock cycles.
- R7: Only slots that received a byte are written. The other bytes of the page keep their previous contents.
- R8: A stop with no staged byte leaves `busy` at 0 and writes nothing.
- R9: A start marker that arrives before the stop drops all staged bytes, so a following stop writes nothing and does not raise `busy`.
- R10: While `busy` is high, address loads, byte strobes, start and stop markers are all ignored. The staged flags are clear when `busy` falls.
- R11: `rd_data` follows `rd_addr` combinationally, without waiting for a clock edge.
- R12: When several strobes occur in the same cycle, one is acted on in this order: start first, then address load, then byte, then stop. A start or an address load also drops the staged bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_load | input | 1 | Loads a new starting word address |
| addr_in | input | 7 | Starting word address |
| byte_stb | input | 1 | One received data byte |
| byte_in | input | 8 | Data byte value |
| start_seen | input | 1 | Start condition marker |
| stop_seen | input | 1 | Stop condition marker |
| rd_addr | input | 7 | Read port address |
| rd_data | output | 8 | Array contents at `rd_addr` |
| busy | output | 1 | Write cycle in progress |

## Verification
The checker tests the following on every cycle:
- `busy` can rise only after a stop that arrives while idle and with staged data.
- Each busy window lasts exactly `WR_CYCLES` cycles.
- Array write enables occur only inside the window and only for flagged slots.
- The staged flags stay frozen while the cycle runs and are clear when it ends.
- Each accepted byte keeps the page and advances the slot by one.

Other properties depend on data values and on what the array holds afterwards, so only the bench's scenarios can show them. These are wrap-around placement within a page, overwrite on a fifth byte, the discard on start, and the array staying unchanged until the window closes.

// File: rtl/pwb_pkg.sv
// Package: shared widths and the write-cycle phase type for the page buffer.
// Assumes a byte array whose word address splits into page and slot fields.
package pwb_pkg;
    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 8;
    localparam int SLOT_W  = 2;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_PROG = 1'b1
    } prog_phase_t;
endpackage

// File: rtl/pwb_addr_ctr.sv
// Address counter: holds the page field and the slot index.
// On a load it takes both fields from the input. On an advance it steps
// only the slot index, which wraps within the page.
// Assumes load and advance are never asserted together; the top resolves priority.
module pwb_addr_ctr #(
    parameter int PAGE_W = 5,
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PAGE_W+SLOT_W-1:0] addr_in,
    input  logic              adv,
    output logic [PAGE_W-1:0] page,
    output logic [SLOT_W-1:0] slot
);
    // Load the page and slot fields, or step the slot index modulo the page size.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page <= '0;
            slot <= '0;
        end else if (load) begin
            page <= addr_in[PAGE_W+SLOT_W-1:SLOT_W];
            slot <= addr_in[SLOT_W-1:0];
        end else if (adv) begin
            slot <= slot + 1'b1;
        end
    end
endmodule

// File: rtl/pwb_page_buf.sv
// Staging buffer: one data register and one valid flag per slot of a page.
// Assumes clear and write are exclusive; clear wins if both are asserted.
module pwb_page_buf #(
    parameter int SLOT_W = 2,
    parameter int DATA_W = 8,
    localparam int SLOTS = 1 << SLOT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    wr_en,
    input  logic [SLOT_W-1:0]       wr_slot,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [SLOTS*DATA_W-1:0] data_flat,
    output logic [SLOTS-1:0]        valid
);
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic hit;
        assign hit = wr_en && (wr_slot == SLOT_W'(s));

        // Capture the byte aimed at this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_flat[s*DATA_W +: DATA_W] <= '0;
            end else if (hit) begin
                data_flat[s*DATA_W +: DATA_W] <= wr_data;
            end
        end

        // Set the valid flag on a write and drop it on a clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid[s] <= 1'b0;
            end else if (clear) begin
                valid[s] <= 1'b0;
            end else if (hit) begin
                valid[s] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwb_cycle_timer.sv
// Write-cycle timer. A go pulse starts a window of exactly WR_CYCLES cycles,
// and commit pulses in the last cycle of that window.
// Assumes WR_CYCLES >= 1 and that go is not asserted while busy.
module pwb_cycle_timer #(
    parameter int WR_CYCLES = 500000,
    localparam int CNT_W = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy,
    output logic commit
);
    import pwb_pkg::*;

    prog_phase_t      phase;
    logic [CNT_W-1:0] remain;

    assign busy   = (phase == PH_PROG);
    assign commit = busy && (remain == '0);

    // Enter the program phase on go, count down, and leave when the count is exhausted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            remain <= '0;
        end else if (phase == PH_IDLE) begin
            if (go) begin
                phase  <= PH_PROG;
                remain <= CNT_W'(WR_CYCLES - 1);
            end
        end else if (remain == '0) begin
            phase <= PH_IDLE;
        end else begin
            remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/pwb_array.sv
// Register-based byte array. It writes a masked set of slots within one page
// in a single cycle and has a combinational read port.
// Assumes the depth is a whole number of pages.
module pwb_array #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8,
    parameter int SLOT_W = 2,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int SLOTS  = 1 << SLOT_W,
    localparam int PAGE_W = ADDR_W - SLOT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SLOTS-1:0]        we_mask,
    input  logic [PAGE_W-1:0]       wr_page,
    input  logic [SLOTS*DATA_W-1:0] wr_flat,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [DATA_W-1:0]       rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  we_word;

    for (genvar w = 0; w < DEPTH; w++) begin : g_we
        localparam logic [ADDR_W-1:0] WA = ADDR_W'(w);
        assign we_word[w] = we_mask[WA[SLOT_W-1:0]] && (wr_page == WA[ADDR_W-1:SLOT_W]);
    end

    // Clear every word on reset, then update the words selected by the mask.
    always_ff @(posedge clk) begin
        for (int w = 0; w < DEPTH; w++) begin
            if (!rst_n) begin
                mem[w] <= '0;
            end else if (we_word[w]) begin
                mem[w] <= wr_flat[(w % SLOTS)*DATA_W +: DATA_W];
            end
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/pwb_commit_top.sv
// Page write buffer top. It gates the engine's strobes while a write cycle runs,
// applies the start > load > byte > stop priority, stages bytes and commits
// them to the array when the timed window ends.
// Assumes the strobes are single-cycle pulses that are already synchronous to clk.
module pwb_commit_top #(
    parameter int ADDR_W    = pwb_pkg::ADDR_W,
    parameter int DATA_W    = pwb_pkg::DATA_W,
    parameter int SLOT_W    = pwb_pkg::SLOT_W,
    parameter int WR_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_in,
    input  logic              start_seen,
    input  logic              stop_seen,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy
);
    localparam int SLOTS  = 1 << SLOT_W;
    localparam int PAGE_W = ADDR_W - SLOT_W;

    logic                    live;
    logic                    acc_start, acc_load, acc_byte, acc_stop;
    logic                    commit;
    logic                    buf_clear;
    logic [PAGE_W-1:0]       page;
    logic [SLOT_W-1:0]       slot;
    logic [SLOTS-1:0]        valid;
    logic [SLOTS*DATA_W-1:0] staged;
    logic [SLOTS-1:0]        we_mask;

    // Accept strobes only while idle, and act on at most one per cycle in priority order.
    always_comb begin
        live      = !busy;
        acc_start = live && start_seen;
        acc_load  = live && !start_seen && addr_load;
        acc_byte  = live && !start_seen && !addr_load && byte_stb;
        acc_stop  = live && !start_seen && !addr_load && !byte_stb && stop_seen && (|valid);
    end

    assign buf_clear = acc_start || acc_load || commit;
    assign we_mask   = commit ? valid : '0;

    pwb_addr_ctr #(.PAGE_W(PAGE_W), .SLOT_W(SLOT_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (acc_load),
        .addr_in (addr_in),
        .adv     (acc_byte),
        .page    (page),
        .slot    (slot)
    );

    pwb_page_buf #(.SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (buf_clear),
        .wr_en     (acc_byte),
        .wr_slot   (slot),
        .wr_data   (byte_in),
        .data_flat (staged),
        .valid     (valid)
    );

    pwb_cycle_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (acc_stop),
        .busy   (busy),
        .commit (commit)
    );

    pwb_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_mask (we_mask),
        .wr_page (page),
        .wr_flat (staged),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/pwb_checker.sv
// Checker for pwb_commit_top: temporal properties on the busy window,
// the staging flags and the address counter. It is attached by bind below.
module pwb_checker #(
    parameter int WR_CYCLES = 500000,
    parameter int SLOTS     = 4,
    parameter int PAGE_W    = 5,
    parameter int SLOT_W    = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              commit,
    input logic              stop_seen,
    input logic              acc_byte,
    input logic [SLOTS-1:0]  valid,
    input logic [SLOTS-1:0]  we_mask,
    input logic [PAGE_W-1:0] page,
    input logic [SLOT_W-1:0] slot
);
    int unsigned run_len;

    // Length of the current run of busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= 0;
    end

    AST_BUSY_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(stop_seen) && ($past(valid) != '0))); // R6 R8

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == WR_CYCLES)); // R6

    AST_WRITE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (we_mask != '0) |-> busy); // R5

    AST_WRITE_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ((we_mask & ~valid) == '0)); // R7

    AST_FLAGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !commit) |=> $stable(valid)); // R10

    AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (valid == '0)); // R10

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        acc_byte |=> ($stable(page) && (slot == SLOT_W'($past(slot) + 1'b1)))); // R3
endmodule

bind pwb_commit_top pwb_checker #(
    .WR_CYCLES (WR_CYCLES),
    .SLOTS     (SLOTS),
    .PAGE_W    (PAGE_W),
    .SLOT_W    (SLOT_W)
) u_pwb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .commit    (commit),
    .stop_seen (stop_seen),
    .acc_byte  (acc_byte),
    .valid     (valid),
    .we_mask   (we_mask),
    .page      (page),
    .slot      (slot)
);

// File: tb/pwb_commit_top_bench.sv
// Bench for pwb_commit_top. A behavioural reference model is stepped on every
// rising edge and compared a quarter period later. Directed scenarios add
// checks tagged with the requirement they cover.
module pwb_commit_top_bench;
    localparam int CLK_P = 10;
    localparam int WCYC  = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_load = 1'b0;
    logic [6:0] addr_in = '0;
    logic       byte_stb = 1'b0;
    logic [7:0] byte_in = '0;
    logic       start_seen = 1'b0;
    logic       stop_seen = 1'b0;
    logic [6:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       busy;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    // reference model state
    int ref_mem [128];
    int ref_buf [4];
    bit ref_val [4];
    int ref_page = 0;
    int ref_slot = 0;
    bit ref_busy = 1'b0;
    int ref_cnt = 0;

    pwb_commit_top #(.WR_CYCLES(WCYC)) u_pwb_commit_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_load  (addr_load),
        .addr_in    (addr_in),
        .byte_stb   (byte_stb),
        .byte_in    (byte_in),
        .start_seen (start_seen),
        .stop_seen  (stop_seen),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .busy       (busy)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Step the model on each edge, then compare once the outputs have settled.
    always @(posedge clk) begin
        bit any;
        if (!rst_n) begin
            foreach (ref_mem[i]) ref_mem[i] = 0;
            foreach (ref_val[i]) begin ref_val[i] = 0; ref_buf[i] = 0; end
            ref_page = 0; ref_slot = 0; ref_busy = 0; ref_cnt = 0;
        end else if (ref_busy) begin
            if (ref_cnt == 0) begin
                foreach (ref_val[i])
                    if (ref_val[i]) ref_mem[ref_page*4 + i] = ref_buf[i];
                foreach (ref_val[i]) ref_val[i] = 0;
                ref_busy = 0;
            end else begin
                ref_cnt--;
            end
        end else begin
            any = 0;
            foreach (ref_val[i]) any |= ref_val[i];
            if (start_seen) begin
                foreach (ref_val[i]) ref_val[i] = 0;
            end else if (addr_load) begin
                ref_page = addr_in / 4; ref_slot = addr_in % 4;
                foreach (ref_val[i]) ref_val[i] = 0;
            end else if (byte_stb) begin
                ref_buf[ref_slot] = byte_in; ref_val[ref_slot] = 1;
                ref_slot = (ref_slot + 1) % 4;
            end else if (stop_seen && any) begin
                ref_busy = 1; ref_cnt = WCYC - 1;
            end
        end
        #(CLK_P/4);
        if (rst_n && !done) begin
            check("R6 busy per-cycle", busy, ref_busy);
            check("R11 rd_data per-cycle", rd_data, ref_mem[rd_addr]);
        end
    end

    task automatic pulse_load(input int a);
        @(negedge clk); addr_load = 1'b1; addr_in = 7'(a);
        @(negedge clk); addr_load = 1'b0;
    endtask

    task automatic pulse_byte(input int d);
        @(negedge clk); byte_stb = 1'b1; byte_in = 8'(d);
        @(negedge clk); byte_stb = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop_seen = 1'b1;
        @(negedge clk); stop_seen = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start_seen = 1'b1;
        @(negedge clk); start_seen = 1'b0;
    endtask

    task automatic read_at(input string req, input int a, input int exp);
        @(negedge clk); rd_addr = 7'(a); #1;
        check(req, rd_data, exp);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", busy, 0);
        read_at("R1 array zero", 7'h05, 0);
        read_at("R1 array zero", 7'h7f, 0);

        // single byte: placement, deferred commit, exact window
        pulse_load(7'h25);
        pulse_byte(8'hA5);
        read_at("R5 no change before stop", 7'h25, 0);
        pulse_stop();
        check("R6 busy after stop", busy, 1);
        rd_addr = 7'h25; #1;
        check("R5 array unchanged in window", rd_data, 0);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        check("R6 window length", n, WCYC);
        rd_addr = 7'h25; #1;
        check("R5 data visible after window", rd_data, 8'hA5);
        read_at("R2 first byte at loaded address", 7'h25, 8'hA5);
        read_at("R7 neighbour below kept", 7'h24, 0);
        read_at("R7 neighbour above kept", 7'h26, 0);

        // slot wrap inside page 0x12 starting at slot 2
        pulse_load(7'h4A);
        pulse_byte(8'h11);
        pulse_byte(8'h22);
        pulse_byte(8'h33);
        pulse_stop();
        wait_idle();
        read_at("R3 slot 2", 7'h4A, 8'h11);
        read_at("R3 slot 3", 7'h4B, 8'h22);
        read_at("R3 wrap to slot 0 same page", 7'h48, 8'h33);
        read_at("R3 next page untouched", 7'h4C, 0);
        read_at("R7 unwritten slot kept", 7'h49, 0);

        // six bytes overwrite slots 0 and 1
        pulse_load(7'h10);
        for (int i = 0; i < 6; i++) pulse_byte(8'hB0 + i);
        pulse_stop();
        wait_idle();
        read_at("R4 slot 0 overwritten", 7'h10, 8'hB4);
        read_at("R4 slot 1 overwritten", 7'h11, 8'hB5);
        read_at("R4 slot 2", 7'h12, 8'hB2);
        read_at("R4 slot 3", 7'h13, 8'hB3);

        // stop with no data
        pulse_load(7'h20);
        pulse_stop();
        check("R8 no busy without data", busy, 0);
        read_at("R8 nothing written", 7'h20, 0);

        // start discards staged data
        pulse_load(7'h30);
        pulse_byte(8'h77);
        pulse_start();
        pulse_stop();
        check("R9 no busy after discard", busy, 0);
        read_at("R9 discarded byte not written", 7'h30, 0);

        // strobes during the window are ignored
        pulse_load(7'h60);
        pulse_byte(8'h01);
        pulse_stop();
        check("R10 window open", busy, 1);
        pulse_load(7'h70);
        pulse_byte(8'h99);
        pulse_stop();
        wait_idle();
        read_at("R10 ignored byte absent", 7'h70, 0);
        read_at("R10 window data written", 7'h60, 8'h01);
        pulse_stop();
        check("R10 flags cleared, stop idle", busy, 0);

        // simultaneous strobes: load beats byte, start beats stop
        @(negedge clk); addr_load = 1'b1; addr_in = 7'h34; byte_stb = 1'b1; byte_in = 8'h55;
        @(negedge clk); addr_load = 1'b0; byte_stb = 1'b0;
        pulse_byte(8'h66);
        @(negedge clk); start_seen = 1'b1; stop_seen = 1'b1;
        @(negedge clk); start_seen = 1'b0; stop_seen = 1'b0;
        check("R12 start beats stop", busy, 0);
        pulse_load(7'h34);
        pulse_byte(8'h66);
        pulse_stop();
        wait_idle();
        read_at("R12 load beat byte, slot from load", 7'h34, 8'h66);
        read_at("R12 byte with load dropped", 7'h35, 0);

        // combinational read: address change without clock edge
        @(negedge clk); rd_addr = 7'h4B; #1;
        check("R11 comb read a", rd_data, 8'h22);
        rd_addr = 7'h13; #1;
        check("R11 comb read b", rd_data, 8'hB3);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule